// File: doc/BRIEF.md
# Four-Function Ripple-Carry ALU

This block is a purely combinational arithmetic and logic unit for operands of a parameterised width. A two-bit operation select picks addition, subtraction, bitwise AND or bitwise OR of two operands. Along with the result it reports a carry-out, a signed-overflow flag and a zero flag.

Addition and subtraction share one chain of one-bit full adders, each passing its carry to the next bit up. For subtraction, every bit of the second operand passes through an XOR gate driven by the subtract control. The same control feeds the carry into bit 0, so the chain forms A + ~B + 1. Signed overflow is the XOR of the carry entering the top bit and the carry leaving it. The carry-out alone would not give a correct signed indication.

The unit has no clock and no state. It is meant to sit between the operand read stage and the result stage of a datapath, and its outputs settle within one combinational path.

Top module: `rc_alu4`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result` equals (`opnd_a` + `opnd_b`) modulo 2^W.
- R2: With `op_sel` = 2'b01 (subtract), `result` equals (`opnd_a` - `opnd_b`) modulo 2^W.
- R3: With `op_sel` = 2'b10, `result` is the bitwise AND of the two operands.
- R4: With `op_sel` = 2'b11, `result` is the bitwise OR of the two operands.
- R5: `carry_out` is the carry leaving the top bit of the adder chain. For add it is 1 exactly when the unsigned sum exceeds 2^W - 1. For subtract it is 1 exactly when `opnd_a` >= `opnd_b` as unsigned numbers, meaning no borrow.
- R6: For add and subtract, `ovf_flag` is 1 exactly when the two's-complement result does not fit in W bits. In that case the operands' effective signs agree and the result's sign differs from them.
- R7: `zero_flag` is 1 exactly when every bit of `result` is 0. This holds for all four operations.
- R8: For AND and OR, `carry_out` and `ovf_flag` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand; it is inverted when subtracting |
| op_sel | input | 2 | Operation select: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | W | Selected result |
| carry_out | output | 1 | Carry out of the top adder bit for arithmetic operations, 0 for logic operations |
| ovf_flag | output | 1 | Signed overflow for arithmetic operations, 0 for logic operations |
| zero_flag | output | 1 | 1 when `result` is all zeros |

## Verification
The main instance is built with W = 8. At that width every first operand can be swept against the boundary second operands (0, 1, 0x7F, 0x80, 0xFF and the operand itself) for all four operations. This reaches every carry-out, borrow and signed-overflow corner, and every path to an all-zero result. A second instance at the default W = 32 checks that a carry ripples through the full chain length and that the signed limits of the wide word raise overflow.

// File: rtl/rc_alu4_pkg.sv
package rc_alu4_pkg;

    localparam int OP_BITS = 2;

    typedef enum logic [OP_BITS-1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_AND = 2'b10,
        ALU_OR  = 2'b11
    } alu_op_e;

    function automatic logic is_arith(input alu_op_e op);
        return (op == ALU_ADD) || (op == ALU_SUB);
    endfunction

endpackage

// File: rtl/rc_alu4_fa_cell.sv
module rc_alu4_fa_cell (
    input  logic bit_a,
    input  logic bit_b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic half_x;

    always_comb begin
        half_x = bit_a ^ bit_b;
        sum    = half_x ^ cin;
        cout   = (bit_a & bit_b) | (half_x & cin);
    end
endmodule

// File: rtl/rc_alu4_chain.sv
module rc_alu4_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    input  logic         cin0,
    output logic [W-1:0] sum,
    output logic [W:0]   carry
);
    assign carry[0] = cin0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        rc_alu4_fa_cell u_cell (
            .bit_a (add_a[i]),
            .bit_b (add_b[i]),
            .cin   (carry[i]),
            .sum   (sum[i]),
            .cout  (carry[i+1])
        );
    end

    // R1 / R2: ripple sum agrees with behavioural addition including carry-in
    always_comb begin
        p_chain_sum_r1: assert ({carry[W], sum} == ({1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, cin0}))
            else $error("chain sum mismatch");
    end
endmodule

// File: rtl/rc_alu4_flags.sv
module rc_alu4_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         arith,
    input  logic         a_msb,
    input  logic         b_eff_msb,
    input  logic         c_into_msb,
    input  logic         c_out_msb,
    output logic         carry_flag,
    output logic         ovf,
    output logic         zero
);
    always_comb begin
        carry_flag = arith & c_out_msb;
        ovf        = arith & (c_into_msb ^ c_out_msb);
        zero       = ~|res;
    end

    // R6: carry-based overflow matches the sign rule on operands and result
    always_comb begin
        if (arith) begin
            p_ovf_sign_r6: assert (ovf == ((a_msb == b_eff_msb) && (res[W-1] != a_msb)))
                else $error("overflow disagrees with sign rule");
        end
    end

    // R8: logic operations never raise arithmetic flags
    always_comb begin
        if (!arith) begin
            p_logic_flags_r8: assert (!carry_flag && !ovf)
                else $error("flag set on logic operation");
        end
    end
endmodule

// File: rtl/rc_alu4.sv
module rc_alu4
    import rc_alu4_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf_flag,
    output logic         zero_flag
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         sub;
        logic         arith;
    } alu_sel_t;

    alu_op_e      op;
    alu_sel_t     sel_d;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic [W:0]   carry;
    logic         c_flag;
    logic         v_flag;
    logic         z_flag;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        sel_d.sub   = (op == ALU_SUB);
        sel_d.arith = is_arith(op);
        b_eff       = opnd_b ^ {W{sel_d.sub}};
        unique case (op)
            ALU_AND: sel_d.res = opnd_a & opnd_b;
            ALU_OR:  sel_d.res = opnd_a | opnd_b;
            default: sel_d.res = sum;
        endcase
    end

    rc_alu4_chain #(.W(W)) u_chain (
        .add_a (opnd_a),
        .add_b (b_eff),
        .cin0  (sel_d.sub),
        .sum   (sum),
        .carry (carry)
    );

    rc_alu4_flags #(.W(W)) u_flags (
        .res        (sel_d.res),
        .arith      (sel_d.arith),
        .a_msb      (opnd_a[MSB]),
        .b_eff_msb  (b_eff[MSB]),
        .c_into_msb (carry[MSB]),
        .c_out_msb  (carry[W]),
        .carry_flag (c_flag),
        .ovf        (v_flag),
        .zero       (z_flag)
    );

    assign result    = sel_d.res;
    assign carry_out = c_flag;
    assign ovf_flag  = v_flag;
    assign zero_flag = z_flag;

    // R2 / R5: subtract result and no-borrow carry
    always_comb begin
        if (op == ALU_SUB) begin
            p_sub_borrow_r5: assert (carry_out == (opnd_a >= opnd_b))
                else $error("subtract carry is not the no-borrow indication");
            p_sub_value_r2: assert (result == W'(opnd_a - opnd_b))
                else $error("subtract result mismatch");
        end
    end
endmodule

// File: tb/rc_alu4_test.sv
module rc_alu4_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NVEC = 13;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] a, b, res;
    logic [1:0]   op;
    logic         c, v, z;

    logic [31:0]  wa, wb, wres;
    logic [1:0]   wop;
    logic         wc, wv, wz;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    rc_alu4 #(.W(W)) uut (
        .opnd_a(a), .opnd_b(b), .op_sel(op),
        .result(res), .carry_out(c), .ovf_flag(v), .zero_flag(z)
    );

    rc_alu4 #(.W(32)) uut_wide (
        .opnd_a(wa), .opnd_b(wb), .op_sel(wop),
        .result(wres), .carry_out(wc), .ovf_flag(wv), .zero_flag(wz)
    );

    // {op, a, b, result, carry, ovf, zero}
    localparam logic [28:0] VEC [NVEC] = '{
        {2'b00, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0, 1'b0},
        {2'b00, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1},
        {2'b00, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 1'b0},
        {2'b00, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1, 1'b1},
        {2'b01, 8'h50, 8'h20, 8'h30, 1'b1, 1'b0, 1'b0},
        {2'b01, 8'h20, 8'h50, 8'hD0, 1'b0, 1'b0, 1'b0},
        {2'b01, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1, 1'b0},
        {2'b01, 8'h33, 8'h33, 8'h00, 1'b1, 1'b0, 1'b1},
        {2'b01, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b1, 1'b0},
        {2'b10, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0, 1'b0},
        {2'b10, 8'hAA, 8'h55, 8'h00, 1'b0, 1'b0, 1'b1},
        {2'b11, 8'hA0, 8'h05, 8'hA5, 1'b0, 1'b0, 1'b0},
        {2'b11, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}
    };

    function automatic string req_of(input logic [1:0] o);
        case (o)
            2'b00:   return "R1/R5/R6/R7";
            2'b01:   return "R2/R5/R6/R7";
            2'b10:   return "R3/R7/R8";
            default: return "R4/R7/R8";
        endcase
    endfunction

    task automatic check8(input string tag, input logic [W-1:0] er,
                          input logic ec, input logic ev, input logic ez);
        total++;
        if (res !== er || c !== ec || v !== ev || z !== ez) begin
            bad++;
            $display("FAIL %s op=%b a=%h b=%h: got res=%h c=%b v=%b z=%b, expected res=%h c=%b v=%b z=%b",
                     tag, op, a, b, res, c, v, z, er, ec, ev, ez);
        end
    endtask

    task automatic model_check(input logic [1:0] o, input logic [W-1:0] xa, input logic [W-1:0] xb);
        logic [W:0]   ext;
        logic [W-1:0] er;
        logic         ec, ev;
        @(negedge clk);
        op = o; a = xa; b = xb;
        #(CLK_PERIOD/4);
        ec = 1'b0; ev = 1'b0;
        case (o)
            2'b00: begin
                ext = {1'b0, xa} + {1'b0, xb};
                er = ext[W-1:0]; ec = ext[W];
                ev = (xa[W-1] == xb[W-1]) && (er[W-1] != xa[W-1]);
            end
            2'b01: begin
                er = xa - xb; ec = (xa >= xb);
                ev = (xa[W-1] != xb[W-1]) && (er[W-1] != xa[W-1]);
            end
            2'b10: er = xa & xb;
            default: er = xa | xb;
        endcase
        check8(req_of(o), er, ec, ev, (er == '0));
    endtask

    task automatic check32(input string tag, input logic [1:0] o, input logic [31:0] xa,
                           input logic [31:0] xb, input logic [31:0] er,
                           input logic ec, input logic ev, input logic ez);
        @(negedge clk);
        wop = o; wa = xa; wb = xb;
        #(CLK_PERIOD/4);
        total++;
        if (wres !== er || wc !== ec || wv !== ev || wz !== ez) begin
            bad++;
            $display("FAIL %s wide: got res=%h c=%b v=%b z=%b, expected res=%h c=%b v=%b z=%b",
                     tag, wres, wc, wv, wz, er, ec, ev, ez);
        end
    endtask

    initial begin
        a = '0; b = '0; op = 2'b00;
        wa = '0; wb = '0; wop = 2'b00;
        // start-up state: all-zero add gives zero result and zero flag (R1, R7)
        @(negedge clk);
        #(CLK_PERIOD/4);
        check8("R1/R7 start", 8'h00, 1'b0, 1'b0, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            op = VEC[i][28:27]; a = VEC[i][26:19]; b = VEC[i][18:11];
            #(CLK_PERIOD/4);
            check8(req_of(op), VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
                logic [W-1:0] xb;
                case (ib)
                    0: xb = 8'h00;
                    1: xb = 8'h01;
                    2: xb = 8'h7F;
                    3: xb = 8'h80;
                    4: xb = 8'hFF;
                    default: xb = W'(ia);
                endcase
                for (int io = 0; io < 4; io++) begin
                    model_check(2'(io), W'(ia), xb);
                end
            end
        end

        // wide instance: full-length ripple and signed limits
        check32("R1/R5 ripple", 2'b00, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1, 1'b0, 1'b1);
        check32("R1/R6 max",    2'b00, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0, 1'b1, 1'b0);
        check32("R2/R6 min",    2'b01, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0);
        check32("R2/R5 borrow", 2'b01, 32'h0, 32'h1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        check32("R3/R8 and",    2'b10, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'h0F0F_0000, 1'b0, 1'b0, 1'b0);
        check32("R4/R8 or",     2'b11, 32'h8000_0000, 32'h1, 32'h8000_0001, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule